// File: doc/BRIEF.md
# Wrapping Hardware Stack and Context Sequencer

This block owns the stack pointer of a small 8-bit processor and carries out every automatic save and restore that touches the stack. The pointer is 16 bits wide, but only its six low bits are held in a register. The ten high bits are a hardwired constant, so every stack access falls inside the 64-byte region from 00C0h to 00FFh. The pointer always names the next free byte. Saves write there and then step down. Restores step up and then read.

A single command port requests the operations. The single-byte operations are push and pop. The two-byte operations are subroutine call and return. The five-byte operations are interrupt entry and interrupt return. The sequencer issues exactly one RAM write or read per cycle on a byte-wide port with a combinational read path, and it holds `busy` high for as many cycles as the operation has accesses. Restored values show up on dedicated output registers, together with a one-cycle valid pulse.

The pointer can also be loaded directly, or returned to its top position in a single cycle. Movement past either end of the region wraps silently. The interrupt frame holds only the program counter, X, A and the condition codes. The Y register is never part of it.

Top module: `stack_ctx_seq`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, `sp` reads 00FFh, `busy` is low, and neither `mem_we` nor `mem_re` is active. An asserted reset in the middle of a sequence abandons that sequence.
- R2: Bits 15:6 of `sp`, and of every stack access address, are always 0000_0000_11b. Only bits 5:0 ever change.
- R3: Push (cmd code 1) writes `push_data` at the address in `sp`, then decrements the pointer.
- R4: Pop (cmd code 2) increments the pointer, then reads that address. `pop_data` carries the byte and `pop_valid` pulses in the cycle in which `busy` falls.
- R5: Decrementing from 00C0h gives 00FFh, and incrementing from 00FFh gives 00C0h. No flag is raised and older data is overwritten.
- R6: Call (cmd code 3) writes the low byte of `pc_in` first and the high byte second, leaving the pointer two lower.
- R7: Return (cmd code 4) reads the high byte first and the low byte second. It presents them on `pc_out` with `ret_valid`.
- R8: Interrupt entry (cmd code 5) writes five bytes in this order: PC low, PC high, X, A, CC. The pointer ends five lower and no sixth byte is written.
- R9: Interrupt return (cmd code 6) reads CC, A, X, PC high and PC low, in that order. It presents them on `cc_out`, `a_out`, `x_out` and `pc_out` with `iret_valid`.
- R10: While idle, `sp_wr_en` loads `sp_load` into the low six pointer bits on the next edge. While busy, it is ignored.
- R11: The reset-pointer command (cmd code 7) sets `sp` to 00FFh on the next edge and never raises `busy`.
- R12: `busy` stays high for exactly 1, 2 or 5 cycles (push/pop, call/return, interrupt entry/return), with one access per busy cycle. A command presented while busy is discarded. Code 0 does nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command strobe, taken when idle |
| cmd | input | 3 | Command code |
| push_data | input | 8 | Byte to push |
| pc_in | input | 16 | Program counter to save |
| x_in | input | 8 | X register to save |
| a_in | input | 8 | Accumulator to save |
| cc_in | input | 8 | Condition codes to save |
| sp_wr_en | input | 1 | Direct pointer load strobe |
| sp_load | input | 6 | Value for pointer bits 5:0 |
| busy | output | 1 | Sequence in progress |
| sp | output | 16 | Current stack pointer |
| mem_we | output | 1 | RAM write strobe |
| mem_re | output | 1 | RAM read strobe |
| mem_addr | output | 16 | RAM address |
| mem_wdata | output | 8 | RAM write byte |
| mem_rdata | input | 8 | RAM read byte, same cycle |
| pop_valid | output | 1 | Pop result valid pulse |
| pop_data | output | 8 | Popped byte |
| ret_valid | output | 1 | Return result valid pulse |
| iret_valid | output | 1 | Interrupt-return result valid pulse |
| pc_out | output | 16 | Restored program counter |
| x_out | output | 8 | Restored X |
| a_out | output | 8 | Restored accumulator |
| cc_out | output | 8 | Restored condition codes |

## Verification
A command is sampled on an edge, and its first access happens in the cycle after it. The result registers and the falling edge of `busy` arrive together, N cycles after acceptance, where N is the access count. A direct load or a reset-pointer command shows on `sp` one cycle after its strobe. The bench drives inputs and samples outputs on falling edges. It counts busy cycles until `busy` drops, and it checks restored values, valid pulses and the pointer in that same cycle, against a model stack that it updates itself.

// File: rtl/stk_pkg.sv
package stk_pkg;

    typedef enum logic [2:0] {
        CMD_NOP  = 3'd0,
        CMD_PUSH = 3'd1,
        CMD_POP  = 3'd2,
        CMD_CALL = 3'd3,
        CMD_RET  = 3'd4,
        CMD_INT  = 3'd5,
        CMD_IRET = 3'd6,
        CMD_RSP  = 3'd7
    } stk_cmd_e;

    typedef enum logic [2:0] {
        FLD_BYTE = 3'd0,
        FLD_PCL  = 3'd1,
        FLD_PCH  = 3'd2,
        FLD_X    = 3'd3,
        FLD_A    = 3'd4,
        FLD_CC   = 3'd5
    } stk_fld_e;

    localparam int STEP_W = 3;

    // number of RAM accesses a command needs
    function automatic logic [STEP_W-1:0] seq_len(stk_cmd_e c);
        case (c)
            CMD_PUSH, CMD_POP:  seq_len = STEP_W'(1);
            CMD_CALL, CMD_RET:  seq_len = STEP_W'(2);
            CMD_INT,  CMD_IRET: seq_len = STEP_W'(5);
            default:            seq_len = '0;
        endcase
    endfunction

    // true for the commands that write the stack
    function automatic logic is_save(stk_cmd_e c);
        is_save = (c == CMD_PUSH) || (c == CMD_CALL) || (c == CMD_INT);
    endfunction

    // which byte is moved at a given step of a sequence
    function automatic stk_fld_e fld_at(stk_cmd_e c, logic [STEP_W-1:0] s);
        fld_at = FLD_BYTE;
        case (c)
            CMD_CALL: fld_at = (s == '0) ? FLD_PCL : FLD_PCH;
            CMD_RET:  fld_at = (s == '0) ? FLD_PCH : FLD_PCL;
            CMD_INT: begin
                case (s)
                    3'd0:    fld_at = FLD_PCL;
                    3'd1:    fld_at = FLD_PCH;
                    3'd2:    fld_at = FLD_X;
                    3'd3:    fld_at = FLD_A;
                    default: fld_at = FLD_CC;
                endcase
            end
            CMD_IRET: begin
                case (s)
                    3'd0:    fld_at = FLD_CC;
                    3'd1:    fld_at = FLD_A;
                    3'd2:    fld_at = FLD_X;
                    3'd3:    fld_at = FLD_PCH;
                    default: fld_at = FLD_PCL;
                endcase
            end
            default: fld_at = FLD_BYTE;
        endcase
    endfunction

endpackage

// File: rtl/stk_pointer.sv
module stk_pointer #(
    parameter int              ADDR_W   = 16,
    parameter int              WIN_BITS = 6,
    parameter logic [15:0]     WIN_BASE = 16'h00C0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rst_ptr,
    input  logic                load_en,
    input  logic [WIN_BITS-1:0] load_val,
    input  logic                inc,
    input  logic                dec,
    output logic [ADDR_W-1:0]   ptr,
    output logic [ADDR_W-1:0]   ptr_above
);
    localparam int                   HI_W = ADDR_W - WIN_BITS;
    localparam logic [HI_W-1:0]      HI   = WIN_BASE[ADDR_W-1:WIN_BITS];
    localparam logic [WIN_BITS-1:0]  TOP  = '1;
    localparam logic [WIN_BITS-1:0]  ONE  = WIN_BITS'(1);

    typedef struct packed {
        logic [WIN_BITS-1:0] low;
    } ptr_t;

    ptr_t ptr_q, ptr_d;

    always_comb begin
        ptr_d = ptr_q;
        if (rst_ptr) begin
            ptr_d.low = TOP;
        end else if (load_en) begin
            ptr_d.low = load_val;
        end else if (dec && !inc) begin
            ptr_d.low = ptr_q.low - ONE;   // wraps inside the window
        end else if (inc && !dec) begin
            ptr_d.low = ptr_q.low + ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ptr_q <= '{low: TOP};
        else        ptr_q <= ptr_d;
    end

    assign ptr       = {HI, ptr_q.low};
    assign ptr_above = {HI, ptr_q.low + ONE};

endmodule

// File: rtl/stk_seq.sv
module stk_seq
    import stk_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cmd_valid,
    input  stk_cmd_e              cmd_in,
    input  logic [DATA_W-1:0]     push_data,
    input  logic [2*DATA_W-1:0]   pc_in,
    input  logic [DATA_W-1:0]     x_in,
    input  logic [DATA_W-1:0]     a_in,
    input  logic [DATA_W-1:0]     cc_in,
    input  logic                  sp_wr_en,
    output logic                  busy,
    output logic                  acc_we,
    output logic                  acc_re,
    output stk_fld_e              acc_fld,
    output logic [DATA_W-1:0]     wdata,
    output logic                  ptr_rst,
    output logic                  ptr_load,
    output logic                  rd_last,
    output stk_cmd_e              cur_op
);
    localparam int PC_W = 2 * DATA_W;

    typedef struct packed {
        logic                busy;
        stk_cmd_e            op;
        logic [STEP_W-1:0]   step;
        logic [STEP_W-1:0]   last;
        logic [DATA_W-1:0]   b;
        logic [DATA_W-1:0]   pcl;
        logic [DATA_W-1:0]   pch;
        logic [DATA_W-1:0]   x;
        logic [DATA_W-1:0]   a;
        logic [DATA_W-1:0]   cc;
    } seq_t;

    seq_t seq_q, seq_d;

    always_comb begin
        seq_d    = seq_q;
        acc_we   = 1'b0;
        acc_re   = 1'b0;
        acc_fld  = FLD_BYTE;
        wdata    = '0;
        ptr_rst  = 1'b0;
        ptr_load = 1'b0;
        rd_last  = 1'b0;

        if (!seq_q.busy) begin
            ptr_load = sp_wr_en;
            if (cmd_valid) begin
                case (cmd_in)
                    CMD_RSP: ptr_rst = 1'b1;
                    CMD_NOP: ;
                    default: begin
                        seq_d.busy = 1'b1;
                        seq_d.op   = cmd_in;
                        seq_d.step = '0;
                        seq_d.last = seq_len(cmd_in) - STEP_W'(1);
                        seq_d.b    = push_data;
                        seq_d.pcl  = pc_in[DATA_W-1:0];
                        seq_d.pch  = pc_in[PC_W-1:DATA_W];
                        seq_d.x    = x_in;
                        seq_d.a    = a_in;
                        seq_d.cc   = cc_in;
                    end
                endcase
            end
        end else begin
            acc_fld = fld_at(seq_q.op, seq_q.step);
            acc_we  = is_save(seq_q.op);
            acc_re  = !acc_we;
            case (acc_fld)
                FLD_PCL: wdata = seq_q.pcl;
                FLD_PCH: wdata = seq_q.pch;
                FLD_X:   wdata = seq_q.x;
                FLD_A:   wdata = seq_q.a;
                FLD_CC:  wdata = seq_q.cc;
                default: wdata = seq_q.b;
            endcase
            if (!acc_we) wdata = '0;
            rd_last    = acc_re && (seq_q.step == seq_q.last);
            seq_d.step = seq_q.step + STEP_W'(1);
            if (seq_q.step == seq_q.last) seq_d.busy = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    assign busy   = seq_q.busy;
    assign cur_op = seq_q.op;

endmodule

// File: rtl/stk_restore.sv
module stk_restore
    import stk_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  rd_en,
    input  stk_fld_e              rd_fld,
    input  logic [DATA_W-1:0]     rdata,
    input  logic                  rd_last,
    input  stk_cmd_e              op,
    output logic                  pop_valid,
    output logic [DATA_W-1:0]     pop_data,
    output logic                  ret_valid,
    output logic                  iret_valid,
    output logic [2*DATA_W-1:0]   pc_out,
    output logic [DATA_W-1:0]     x_out,
    output logic [DATA_W-1:0]     a_out,
    output logic [DATA_W-1:0]     cc_out
);
    typedef struct packed {
        logic [DATA_W-1:0] byte_v;
        logic [DATA_W-1:0] pcl;
        logic [DATA_W-1:0] pch;
        logic [DATA_W-1:0] x;
        logic [DATA_W-1:0] a;
        logic [DATA_W-1:0] cc;
        logic              pop_v;
        logic              ret_v;
        logic              iret_v;
    } rst_t;

    rst_t res_q, res_d;

    always_comb begin
        res_d        = res_q;
        res_d.pop_v  = 1'b0;
        res_d.ret_v  = 1'b0;
        res_d.iret_v = 1'b0;
        if (rd_en) begin
            case (rd_fld)
                FLD_PCL: res_d.pcl    = rdata;
                FLD_PCH: res_d.pch    = rdata;
                FLD_X:   res_d.x      = rdata;
                FLD_A:   res_d.a      = rdata;
                FLD_CC:  res_d.cc     = rdata;
                default: res_d.byte_v = rdata;
            endcase
        end
        if (rd_last) begin
            res_d.pop_v  = (op == CMD_POP);
            res_d.ret_v  = (op == CMD_RET);
            res_d.iret_v = (op == CMD_IRET);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign pop_valid  = res_q.pop_v;
    assign pop_data   = res_q.byte_v;
    assign ret_valid  = res_q.ret_v;
    assign iret_valid = res_q.iret_v;
    assign pc_out     = {res_q.pch, res_q.pcl};
    assign x_out      = res_q.x;
    assign a_out      = res_q.a;
    assign cc_out     = res_q.cc;

endmodule

// File: rtl/stack_ctx_seq.sv
module stack_ctx_seq
    import stk_pkg::*;
#(
    parameter int          ADDR_W   = 16,
    parameter int          DATA_W   = 8,
    parameter int          WIN_BITS = 6,
    parameter logic [15:0] WIN_BASE = 16'h00C0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cmd_valid,
    input  logic [2:0]            cmd,
    input  logic [DATA_W-1:0]     push_data,
    input  logic [2*DATA_W-1:0]   pc_in,
    input  logic [DATA_W-1:0]     x_in,
    input  logic [DATA_W-1:0]     a_in,
    input  logic [DATA_W-1:0]     cc_in,
    input  logic                  sp_wr_en,
    input  logic [WIN_BITS-1:0]   sp_load,
    output logic                  busy,
    output logic [ADDR_W-1:0]     sp,
    output logic                  mem_we,
    output logic                  mem_re,
    output logic [ADDR_W-1:0]     mem_addr,
    output logic [DATA_W-1:0]     mem_wdata,
    input  logic [DATA_W-1:0]     mem_rdata,
    output logic                  pop_valid,
    output logic [DATA_W-1:0]     pop_data,
    output logic                  ret_valid,
    output logic                  iret_valid,
    output logic [2*DATA_W-1:0]   pc_out,
    output logic [DATA_W-1:0]     x_out,
    output logic [DATA_W-1:0]     a_out,
    output logic [DATA_W-1:0]     cc_out
);
    logic        acc_we, acc_re, ptr_rst, ptr_load, rd_last;
    stk_fld_e    acc_fld;
    stk_cmd_e    cur_op;
    logic [ADDR_W-1:0] ptr_cur, ptr_up;

    stk_seq #(.DATA_W(DATA_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_in    (stk_cmd_e'(cmd)),
        .push_data (push_data),
        .pc_in     (pc_in),
        .x_in      (x_in),
        .a_in      (a_in),
        .cc_in     (cc_in),
        .sp_wr_en  (sp_wr_en),
        .busy      (busy),
        .acc_we    (acc_we),
        .acc_re    (acc_re),
        .acc_fld   (acc_fld),
        .wdata     (mem_wdata),
        .ptr_rst   (ptr_rst),
        .ptr_load  (ptr_load),
        .rd_last   (rd_last),
        .cur_op    (cur_op)
    );

    stk_pointer #(
        .ADDR_W   (ADDR_W),
        .WIN_BITS (WIN_BITS),
        .WIN_BASE (WIN_BASE)
    ) u_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .rst_ptr   (ptr_rst),
        .load_en   (ptr_load),
        .load_val  (sp_load),
        .inc       (acc_re),
        .dec       (acc_we),
        .ptr       (ptr_cur),
        .ptr_above (ptr_up)
    );

    stk_restore #(.DATA_W(DATA_W)) u_res (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_en      (acc_re),
        .rd_fld     (acc_fld),
        .rdata      (mem_rdata),
        .rd_last    (rd_last),
        .op         (cur_op),
        .pop_valid  (pop_valid),
        .pop_data   (pop_data),
        .ret_valid  (ret_valid),
        .iret_valid (iret_valid),
        .pc_out     (pc_out),
        .x_out      (x_out),
        .a_out      (a_out),
        .cc_out     (cc_out)
    );

    assign sp       = ptr_cur;
    assign mem_we   = acc_we;
    assign mem_re   = acc_re;
    assign mem_addr = acc_re ? ptr_up : ptr_cur;

endmodule

// File: rtl/stack_ctx_seq_chk.sv
module stack_ctx_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cmd_valid,
    input logic [2:0]  cmd,
    input logic        busy,
    input logic [15:0] sp,
    input logic        mem_we,
    input logic        mem_re,
    input logic [15:0] mem_addr
);
    logic [5:0] sp_lo;
    logic       take;
    assign sp_lo = sp[5:0];
    assign take  = cmd_valid && !busy;

    // R3: a write lands on the free slot, then the pointer steps down
    p_push_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> mem_addr == sp);
    p_post_dec_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> sp_lo == $past(sp_lo) - 6'd1);

    // R4: a read uses the slot above, then the pointer follows it
    p_pre_inc_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |-> mem_addr == {sp[15:6], sp_lo + 6'd1});
    p_post_inc_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |=> sp_lo == $past(sp_lo) + 6'd1);

    // R11: reset-pointer command
    p_rsp_top_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (take && cmd == 3'd7) |=> (sp == 16'h00FF && !busy));

    // R12: one access at a time, and sequence lengths
    p_one_access_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re));
    p_int_len_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (take && cmd == 3'd5) |=> busy ##1 busy ##1 busy ##1 busy ##1 busy ##1 !busy);
    p_call_len_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (take && cmd == 3'd3) |=> busy ##1 busy ##1 !busy);
    p_push_len_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (take && (cmd == 3'd1 || cmd == 3'd2)) |=> busy ##1 !busy);

endmodule

bind stack_ctx_seq stack_ctx_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd       (cmd),
    .busy      (busy),
    .sp        (sp),
    .mem_we    (mem_we),
    .mem_re    (mem_re),
    .mem_addr  (mem_addr)
);

// File: tb/stack_ctx_seq_test.sv
module stack_ctx_seq_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cmd_valid;
    logic [2:0]  cmd;
    logic [7:0]  push_data, x_in, a_in, cc_in;
    logic [15:0] pc_in;
    logic        sp_wr_en;
    logic [5:0]  sp_load;
    logic        busy, mem_we, mem_re;
    logic [15:0] sp, mem_addr;
    logic [7:0]  mem_wdata, mem_rdata;
    logic        pop_valid, ret_valid, iret_valid;
    logic [7:0]  pop_data, x_out, a_out, cc_out;
    logic [15:0] pc_out;

    always #5 clk = ~clk;

    stack_ctx_seq uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd(cmd),
        .push_data(push_data), .pc_in(pc_in), .x_in(x_in), .a_in(a_in),
        .cc_in(cc_in), .sp_wr_en(sp_wr_en), .sp_load(sp_load), .busy(busy),
        .sp(sp), .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .pop_valid(pop_valid),
        .pop_data(pop_data), .ret_valid(ret_valid), .iret_valid(iret_valid),
        .pc_out(pc_out), .x_out(x_out), .a_out(a_out), .cc_out(cc_out)
    );

    // behavioural stack RAM covering the 64-byte region
    logic [7:0] ram  [0:63];
    logic [7:0] mref [0:63];
    logic [5:0] msp;
    int n_chk = 0;
    int n_fail = 0;

    assign mem_rdata = ram[mem_addr[5:0]];
    always @(posedge clk) if (mem_we) ram[mem_addr[5:0]] <= mem_wdata;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // R2: every access stays in the window
    always @(negedge clk) begin
        if (rst_n && (mem_we || mem_re))
            chk("R2 access address high bits", {22'd0, mem_addr[15:6]}, 32'h3);
    end

    // {cmd, byte, pc}
    localparam int NV = 13;
    localparam logic [26:0] VEC [NV] = '{
        {3'd5, 8'h11, 16'h1234},
        {3'd3, 8'h22, 16'hABCD},
        {3'd1, 8'h5A, 16'h0000},
        {3'd1, 8'hA5, 16'h0000},
        {3'd2, 8'h00, 16'h0000},
        {3'd2, 8'h00, 16'h0000},
        {3'd4, 8'h00, 16'h0000},
        {3'd6, 8'h00, 16'h0000},
        {3'd3, 8'h7E, 16'h0F1E},
        {3'd5, 8'h99, 16'h8001},
        {3'd6, 8'h00, 16'h0000},
        {3'd4, 8'h00, 16'h0000},
        {3'd7, 8'h00, 16'h0000}
    };

    task automatic issue(input logic [2:0] c, input logic [7:0] b, input logic [15:0] pc);
        cmd_valid = 1'b1; cmd = c; push_data = b; pc_in = pc;
        x_in = b ^ 8'h33; a_in = b ^ 8'hC3; cc_in = b ^ 8'h0F;
        @(negedge clk);
        cmd_valid = 1'b0; cmd = 3'd0;
    endtask

    task automatic finish(input logic [2:0] c, input logic [7:0] b, input logic [15:0] pc,
                          input int pre);
        int cnt;
        int len;
        logic [7:0] h, l, vx, va, vc, below;
        cnt = pre;
        while (busy && cnt < 20) begin
            cnt++;
            @(negedge clk);
        end
        case (c)
            3'd1, 3'd2: len = 1;
            3'd3, 3'd4: len = 2;
            3'd5, 3'd6: len = 5;
            default:    len = 0;
        endcase
        chk("R12 busy cycle count", cnt, len);
        case (c)
            3'd1: begin
                mref[msp] = b; msp = msp - 6'd1;
                chk("R3 pushed byte at old pointer", ram[msp + 6'd1], b);
            end
            3'd2: begin
                msp = msp + 6'd1;
                chk("R4 pop_valid", pop_valid, 1);
                chk("R4 pop_data", pop_data, mref[msp]);
            end
            3'd3: begin
                mref[msp] = pc[7:0]; msp = msp - 6'd1;
                mref[msp] = pc[15:8]; msp = msp - 6'd1;
                chk("R6 PC low written first", ram[msp + 6'd2], pc[7:0]);
                chk("R6 PC high written second", ram[msp + 6'd1], pc[15:8]);
            end
            3'd4: begin
                msp = msp + 6'd1; h = mref[msp];
                msp = msp + 6'd1; l = mref[msp];
                chk("R7 ret_valid", ret_valid, 1);
                chk("R7 pc_out", pc_out, {h, l});
            end
            3'd5: begin
                below = mref[msp - 6'd5];
                mref[msp] = pc[7:0];    msp = msp - 6'd1;
                mref[msp] = pc[15:8];   msp = msp - 6'd1;
                mref[msp] = b ^ 8'h33;  msp = msp - 6'd1;
                mref[msp] = b ^ 8'hC3;  msp = msp - 6'd1;
                mref[msp] = b ^ 8'h0F;  msp = msp - 6'd1;
                chk("R8 frame PC low", ram[msp + 6'd5], pc[7:0]);
                chk("R8 frame PC high", ram[msp + 6'd4], pc[15:8]);
                chk("R8 frame X", ram[msp + 6'd3], b ^ 8'h33);
                chk("R8 frame A", ram[msp + 6'd2], b ^ 8'hC3);
                chk("R8 frame CC", ram[msp + 6'd1], b ^ 8'h0F);
                chk("R8 no sixth byte", ram[msp], below);
            end
            3'd6: begin
                msp = msp + 6'd1; vc = mref[msp];
                msp = msp + 6'd1; va = mref[msp];
                msp = msp + 6'd1; vx = mref[msp];
                msp = msp + 6'd1; h  = mref[msp];
                msp = msp + 6'd1; l  = mref[msp];
                chk("R9 iret_valid", iret_valid, 1);
                chk("R9 cc_out", cc_out, vc);
                chk("R9 a_out", a_out, va);
                chk("R9 x_out", x_out, vx);
                chk("R9 pc_out", pc_out, {h, l});
            end
            3'd7: begin
                msp = 6'h3F;
                chk("R11 pointer back at top", sp, 16'h00FF);
            end
            default: ;
        endcase
        chk("R2 pointer value", sp, {10'b0000000011, msp});
    endtask

    task automatic run(input logic [2:0] c, input logic [7:0] b, input logic [15:0] pc);
        issue(c, b, pc);
        finish(c, b, pc, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; cmd_valid = 1'b0; cmd = 3'd0; push_data = '0; pc_in = '0;
        x_in = '0; a_in = '0; cc_in = '0; sp_wr_en = 1'b0; sp_load = '0;
        for (int i = 0; i < 64; i++) begin ram[i] = 8'h00; mref[i] = 8'h00; end
        msp = 6'h3F;
        repeat (3) @(negedge clk);
        chk("R1 sp in reset", sp, 16'h00FF);
        chk("R1 busy in reset", busy, 0);
        chk("R1 no access in reset", {mem_we, mem_re}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 sp after reset", sp, 16'h00FF);

        // vector table: mixed pushes, pops, calls and interrupt frames
        for (int v = 0; v < NV; v++)
            run(VEC[v][26:24], VEC[v][23:16], VEC[v][15:0]);

        // R10 direct load, then R5 wrap below the bottom
        sp_wr_en = 1'b1; sp_load = 6'h00;
        @(negedge clk);
        sp_wr_en = 1'b0;
        msp = 6'h00;
        chk("R10 direct load", sp, 16'h00C0);
        run(3'd1, 8'h3C, 16'h0);
        chk("R5 decrement wraps to top", sp, 16'h00FF);
        run(3'd2, 8'h00, 16'h0);
        chk("R5 increment wraps to bottom", sp, 16'h00C0);
        chk("R5 popped across wrap", pop_data, 8'h3C);

        // R8 frame straddling the bottom of the window
        sp_wr_en = 1'b1; sp_load = 6'h02;
        @(negedge clk);
        sp_wr_en = 1'b0;
        msp = 6'h02;
        run(3'd5, 8'h44, 16'h5678);
        chk("R5 frame wrapped pointer", sp, 16'h00FD);
        run(3'd6, 8'h00, 16'h0);

        // R10/R12 strobes while busy are discarded
        issue(3'd5, 8'h66, 16'h9ABC);
        sp_wr_en = 1'b1; sp_load = 6'h10; cmd_valid = 1'b1; cmd = 3'd1; push_data = 8'hEE;
        @(negedge clk);
        sp_wr_en = 1'b0; cmd_valid = 1'b0; cmd = 3'd0;
        finish(3'd5, 8'h66, 16'h9ABC, 1);
        @(negedge clk);
        chk("R12 late command discarded", busy, 0);
        chk("R10 load ignored while busy", sp, {10'b0000000011, msp});
        run(3'd6, 8'h00, 16'h0);

        // R11 reset-pointer command, R12 no-op code
        run(3'd0, 8'h00, 16'h0);
        run(3'd1, 8'h12, 16'h0);
        run(3'd7, 8'h00, 16'h0);

        // R1 reset in the middle of an interrupt entry
        issue(3'd5, 8'h21, 16'h4321);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 sp after mid-sequence reset", sp, 16'h00FF);
        chk("R1 busy after mid-sequence reset", busy, 0);
        rst_n = 1'b1;
        @(negedge clk);
        msp = 6'h3F;
        run(3'd1, 8'h77, 16'h0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule